// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer

This block drives the external bus of a small 8-bit accumulator processor. Each clock is one T-state. Every instruction starts with a four-state opcode fetch from the program counter. The decoded opcode then picks a fixed chain of three-state transfer cycles: memory reads, memory writes or I/O reads. The block drives a 16-bit address bus, an 8-bit write-data bus and active-low read and write strobes. It holds the accumulator, register B, the program counter and a 16-bit memory pointer.

The block recognises four opcodes:

- 34h increments the byte addressed by the pointer.
- 06h loads B with the next program byte.
- 32h stores the accumulator to a 16-bit address taken from the next two program bytes, low byte first.
- DBh reads an I/O port, named by the next program byte, into the accumulator.

Any other opcode costs one fetch and nothing more. A status pair (cycle type and T-state number) exposes the sequence, so the surrounding system can follow it.

Top module: `mcycle_seq`

## Requirements
- R1: While reset is low, and at the first sample after it, the status shows idle (type 0, T-state 0), `rd_n` and `wr_n` are 1, and the program counter, accumulator and B are all 0.
- R2: An opcode fetch (type 1) lasts T1 to T4 and addresses the program counter in T1 to T3. `rd_n` is low in T2 and T3 only, and T4 has no strobe.
- R3: Memory read, memory write and I/O read cycles each last T1 to T3. The strobe is low in T2 and T3. In a write, `dout_en` is 1 and `dout` holds steady through T2 and T3.
- R4: The program counter increments by one after each opcode byte and each operand byte is read.
- R5: Opcode 34h runs fetch, a memory read at the pointer, then a memory write of that byte plus one (modulo 256, so FFh becomes 00h) to the same address.
- R6: Opcode 06h runs fetch, then one memory read at the program counter, and loads that byte into B.
- R7: Opcode 32h runs fetch, reads a low address byte, then a high address byte, then writes the accumulator to {high, low}.
- R8: Opcode DBh runs fetch, reads a port number, then does an I/O read (type 4, `io_m` = 1) with the port number on both address halves, and loads the result into the accumulator.
- R9: Any other opcode runs only the four-state fetch, and the next fetch follows directly.
- R10: The cycle type is encoded as 0 idle, 1 fetch, 2 memory read, 3 memory write, 4 I/O read and 5 I/O write. A non-idle cycle has a T-state between 1 and 4.
- R11: `rd_n` and `wr_n` are never low in the same cycle.
- R12: A pulse on `hl_load` loads `hl_value` into the pointer at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Read data from memory or I/O |
| hl_load | input | 1 | Load the pointer register |
| hl_value | input | 16 | Value for the pointer register |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data |
| dout_en | output | 1 | Write data valid |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for an I/O cycle, 0 for memory |
| cyc_type | output | 3 | Current machine-cycle type |
| tstate | output | 3 | Current T-state number |
| acc_out | output | 8 | Accumulator |
| b_out | output | 8 | Register B |
| pc_out | output | 16 | Program counter |

## Verification
The assertions check the per-cycle rules on every cycle:

- the two strobes never overlap;
- a fetch ends after T4 and a transfer after T3;
- T4 of a fetch is quiet;
- the program counter steps after an opcode byte;
- write data holds steady;
- the port number is mirrored during I/O.

Only the bench's program can show that each opcode produces the right chain of cycles and that data lands where it should. That covers the increment wrapping from FFh to 00h, the store reaching the top address FFFFh, the port value reaching the accumulator, and unknown opcodes costing exactly one fetch.

// File: rtl/mcycle_seq.sv
module mcycle_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  din,
  input  logic        hl_load,
  input  logic [15:0] hl_value,
  output logic [15:0] addr,
  output logic [7:0]  dout,
  output logic        dout_en,
  output logic        rd_n,
  output logic        wr_n,
  output logic        io_m,
  output logic [2:0]  cyc_type,
  output logic [2:0]  tstate,
  output logic [7:0]  acc_out,
  output logic [7:0]  b_out,
  output logic [15:0] pc_out
);
  localparam logic [2:0] C_IDLE = 3'd0, C_OF = 3'd1, C_MR = 3'd2,
                         C_MW = 3'd3, C_IR = 3'd4, C_IW = 3'd5;
  localparam logic [7:0] OP_INCM = 8'h34, OP_LDB = 8'h06,
                         OP_STA = 8'h32, OP_IN = 8'hDB;

  logic [2:0]  cyc, t, step;
  logic [7:0]  op, acc, rb, lo, hi, tmp;
  logic [15:0] pc, hl;

  function automatic logic [2:0] plan(input logic [7:0] o, input logic [2:0] s);
    logic [2:0] r;
    r = C_IDLE;
    case (o)
      OP_INCM: if (s == 3'd1) r = C_MR; else if (s == 3'd2) r = C_MW;
      OP_LDB:  if (s == 3'd1) r = C_MR;
      OP_STA:  if (s == 3'd1 || s == 3'd2) r = C_MR; else if (s == 3'd3) r = C_MW;
      OP_IN:   if (s == 3'd1) r = C_MR; else if (s == 3'd2) r = C_IR;
      default: r = C_IDLE;
    endcase
    return r;
  endfunction

  wire       mid    = (t == 3'd2) || (t == 3'd3);
  wire       is_rd  = (cyc == C_OF) || (cyc == C_MR) || (cyc == C_IR);
  wire       is_wr  = (cyc == C_MW) || (cyc == C_IW);
  wire       endcyc = (cyc != C_IDLE) && (t == ((cyc == C_OF) ? 3'd4 : 3'd3));
  wire [2:0] nxt    = plan(op, step + 3'd1);

  assign rd_n     = !(is_rd && mid);
  assign wr_n     = !(is_wr && mid);
  assign dout_en  = is_wr && mid;
  assign io_m     = (cyc == C_IR) || (cyc == C_IW);
  assign cyc_type = cyc;
  assign tstate   = t;
  assign acc_out  = acc;
  assign b_out    = rb;
  assign pc_out   = pc;
  assign dout     = (cyc == C_MW) ? ((op == OP_INCM) ? tmp + 8'd1 : acc) : 8'd0;

  always_comb begin
    case (cyc)
      C_OF:       addr = pc;
      C_MR:       addr = (op == OP_INCM) ? hl : pc;
      C_MW:       addr = (op == OP_INCM) ? hl : {hi, lo};
      C_IR, C_IW: addr = {lo, lo};
      default:    addr = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= C_IDLE; t <= 3'd0; step <= 3'd0; op <= 8'd0;
      acc <= 8'd0; rb <= 8'd0; lo <= 8'd0; hi <= 8'd0; tmp <= 8'd0;
      pc <= 16'd0; hl <= 16'd0;
    end else begin
      if (hl_load) hl <= hl_value;
      if (cyc == C_IDLE) begin
        cyc <= C_OF; t <= 3'd1; step <= 3'd0;
      end else if (endcyc) begin
        t <= 3'd1;
        if (nxt == C_IDLE) begin
          cyc <= C_OF; step <= 3'd0;
        end else begin
          cyc <= nxt; step <= step + 3'd1;
        end
      end else begin
        t <= t + 3'd1;
      end
      if (t == 3'd3) begin
        case (cyc)
          C_OF: begin op <= din; pc <= pc + 16'd1; end
          C_MR: begin
            if (op == OP_INCM) tmp <= din;
            else begin
              pc <= pc + 16'd1;
              if (op == OP_LDB) rb <= din;
              if (op == OP_IN || (op == OP_STA && step == 3'd1)) lo <= din;
              if (op == OP_STA && step == 3'd2) hi <= din;
            end
          end
          C_IR: acc <= din;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mcycle_seq_chk.sv
module mcycle_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  dout,
  input logic        rd_n,
  input logic        wr_n,
  input logic        io_m,
  input logic [2:0]  cyc_type,
  input logic [2:0]  tstate,
  input logic [15:0] pc_out
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R2
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd1 && tstate == 3'd4) |=> (tstate == 3'd1));
  // R2
  fetch_t4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd1 && tstate == 3'd4) |-> (rd_n && wr_n));
  // R3
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type >= 3'd2 && cyc_type <= 3'd5 && tstate == 3'd3) |=> (tstate == 3'd1));
  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd3 && tstate == 3'd3) |-> $stable(dout));
  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd1 && tstate == 3'd3) |=> (pc_out == $past(pc_out) + 16'd1));
  // R8
  io_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd4 || cyc_type == 3'd5) |-> (io_m && addr[15:8] == addr[7:0]));
  // R10
  tstate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type != 3'd0) |-> (tstate >= 3'd1 && tstate <= 3'd4));
endmodule

bind mcycle_seq mcycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .dout(dout), .rd_n(rd_n), .wr_n(wr_n),
  .io_m(io_m), .cyc_type(cyc_type), .tstate(tstate), .pc_out(pc_out)
);

// File: tb/tb_mcycle_seq.sv
module tb_mcycle_seq;
  logic        clk = 1'b0, rst_n = 1'b0, hl_load = 1'b0;
  logic [7:0]  din = 8'd0;
  logic [15:0] hl_value = 16'd0;
  logic [15:0] addr, pc_out;
  logic [7:0]  dout, acc_out, b_out;
  logic        dout_en, rd_n, wr_n, io_m;
  logic [2:0]  cyc_type, tstate;

  mcycle_seq dut (.clk(clk), .rst_n(rst_n), .din(din), .hl_load(hl_load),
    .hl_value(hl_value), .addr(addr), .dout(dout), .dout_en(dout_en),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .cyc_type(cyc_type),
    .tstate(tstate), .acc_out(acc_out), .b_out(b_out), .pc_out(pc_out));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] mem [int];

  function automatic logic [7:0] rdmem(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  int mcyc = 0, mt = 0, mop = 0, mpc = 0, mhl = 0, mlo = 0, mhi = 0;
  int mtmp = 0, macc = 0, mb = 0, nrd = 0;
  int todo[$];

  always @(negedge clk) begin
    int dv, ea, erd, ewr, tg;
    string tag;
    dv = io_m ? ((addr[7:0] ^ 8'h5A) & 8'hFF) : rdmem(addr);
    din = dv[7:0];
    cycles++;
    erd = ((mcyc == 1 || mcyc == 2 || mcyc == 4) && (mt == 2 || mt == 3)) ? 0 : 1;
    ewr = ((mcyc == 3 || mcyc == 5) && (mt == 2 || mt == 3)) ? 0 : 1;
    case (mcyc)
      1: ea = mpc;
      2: ea = (mop == 'h34) ? mhl : mpc;
      3: ea = (mop == 'h34) ? mhl : (mhi * 256 + mlo);
      4: ea = mlo * 257;
      default: ea = 0;
    endcase
    if (!rst_n) tag = "R1";
    else if (mcyc == 1 && !(mop == 'h34 || mop == 'h06 || mop == 'h32 || mop == 'hDB)) tag = "R9";
    else tag = "R10";
    cmp(tag, "cyc_type", cyc_type, mcyc);
    cmp(tag, "tstate", tstate, mt);
    cmp(!rst_n ? "R1" : (mcyc == 1 ? "R2" : "R3"), "rd_n", rd_n, erd);
    cmp(!rst_n ? "R1" : "R3", "wr_n", wr_n, ewr);
    cmp("R11", "strobe overlap", (!rd_n && !wr_n), 0);
    cmp("R8", "io_m", io_m, (mcyc == 4 || mcyc == 5));
    cmp("R4", "pc_out", pc_out, mpc);
    cmp(!rst_n ? "R1" : "R8", "acc_out", acc_out, macc);
    cmp(!rst_n ? "R1" : "R6", "b_out", b_out, mb);
    if (mcyc != 0 && mt <= 3) begin
      if (mop == 'h34 && (mcyc == 2 || mcyc == 3)) tg = 12;
      else if (mcyc == 4) tg = 8;
      else tg = 2;
      cmp(tg == 12 ? "R12" : (tg == 8 ? "R8" : "R2"), "addr", addr, ea);
    end
    if (mcyc == 3 && (mt == 2 || mt == 3)) begin
      cmp("R3", "dout_en", dout_en, 1);
      cmp(mop == 'h34 ? "R5" : "R7", "dout", dout, (mop == 'h34) ? ((mtmp + 1) & 'hFF) : macc);
    end
    if (!wr_n && tstate == 3'd3 && !io_m) mem[addr] = dout;
    if (rst_n) begin
      if (hl_load) mhl = hl_value;
      if (mcyc == 0) begin mcyc = 1; mt = 1; end
      else begin
        if (mt == 3) begin
          if (mcyc == 1) begin mop = dv; mpc = (mpc + 1) & 'hFFFF; nrd = 0; end
          else if (mcyc == 2) begin
            if (mop == 'h34) mtmp = dv;
            else begin
              mpc = (mpc + 1) & 'hFFFF;
              if (mop == 'h06) mb = dv;
              if (mop == 'hDB || (mop == 'h32 && nrd == 0)) mlo = dv;
              if (mop == 'h32 && nrd == 1) mhi = dv;
              nrd++;
            end
          end else if (mcyc == 4) macc = dv;
        end
        if ((mcyc == 1 && mt == 4) || (mcyc != 1 && mt == 3)) begin
          if (mcyc == 1) begin
            case (mop)
              'h34: todo = '{2, 3};
              'h06: todo = '{2};
              'h32: todo = '{2, 2, 3};
              'hDB: todo = '{2, 4};
              default: todo = {};
            endcase
          end
          mcyc = (todo.size() == 0) ? 1 : todo.pop_front();
          mt = 1;
        end else mt++;
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mem[0] = 8'h06; mem[1] = 8'h43;
    mem[2] = 8'hDB; mem[3] = 8'hC0;
    mem[4] = 8'h32; mem[5] = 8'h6A; mem[6] = 8'h52;
    mem[7] = 8'h34; mem[8] = 8'h34; mem[9] = 8'hFF;
    mem[10] = 8'hDB; mem[11] = 8'h03;
    mem[12] = 8'h32; mem[13] = 8'hFF; mem[14] = 8'hFF;
    mem['h4250] = 8'hFE;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1; hl_load = 1'b1; hl_value = 16'h4250;
    @(posedge clk);
    #1 hl_load = 1'b0; hl_value = 16'h0000;
    repeat (140) @(posedge clk);
    #1;
    cmp("R7", "mem[526A]", rdmem('h526A), 'h9A);
    cmp("R7", "mem[FFFF]", rdmem('hFFFF), 'h59);
    cmp("R5", "mem[4250] after wrap", rdmem('h4250), 'h00);
    cmp("R6", "B final", b_out, 'h43);
    cmp("R8", "acc final", acc_out, 'h59);
    finish_run();
  end
endmodule